// File: doc/BRIEF.md
# Up/Down Position Counter with Dual Compare and Capture

This block keeps a 24-bit position count that moves by one on single-cycle up or down strobes from an upstream pulse decoder. Software-side logic writes a preload value and two compare values through a simple register write port. An asynchronous load pin copies the preload value into the count. An asynchronous latch pin freezes a copy of the count for later reading. An index condition on three further pins clears the count synchronously.

Each compare value drives a coincidence output. In momentary mode the output follows equality with the count. In held mode the output is sticky until its own acknowledge input releases it. An active-low match flag per comparator always shows raw equality.

The count path is decided each cycle by a priority choice among keep, load, clear, up and down. Each comparator runs a two-state machine. In WATCH the output is not held. WATCH goes to HELD when held mode is on, the count equals the compare value and no acknowledge is present. HELD goes back to WATCH on acknowledge or when held mode is turned off.

Top module: `qcnt_compare`

## Requirements
- R1: After reset the count, latch value, preload and both compare values are zero. Both machines are in WATCH.
- R2: A cycle with only `up_stb` high adds one to the count, and a cycle with only `dn_stb` high subtracts one. With both strobes high or both low, the count does not change.
- R3: The count wraps modulo 2^24. Counting up from 0xFFFFFF gives 0, and counting down from 0 gives 0xFFFFFF.
- R4: `load_pin`, `latch_pin`, `idx_z`, `idx_a` and `idx_b` each pass through two synchronizing flops before use. A load event is a rising edge of the synchronized `load_pin`. It puts the preload value into the count on the third clock edge after the pin rises. A load beats any strobe in that cycle.
- R5: A latch event is a rising edge of the synchronized `latch_pin`. It stores, on that same third edge, the count as it was just before that edge. A count update on that edge is not included.
- R6: An index clear sets the count to zero. It needs synchronized `idx_z`=1 and `idx_b`=0 together with an edge of synchronized `idx_a`. The edge is rising when `clr_on_fall`=0 and falling when `clr_on_fall`=1. With `idx_b`=1 or `idx_z`=0, the edge has no effect.
- R7: The count update priority is load first, then index clear, then strobes.
- R8: A write with `wr_en`=1 stores `wr_data` at the next edge. The target depends on `wr_sel`: 0 is the preload, 1 is compare A, 2 is compare B, and 3 changes nothing.
- R9: With its hold input low, a coincidence output is high exactly while the count equals its compare value.
- R10: With its hold input high, a coincidence output rises one cycle after the count first equals the compare value. It stays high after the count moves on, until its acknowledge input is sampled high, and is low the following cycle.
- R11: `match_a_n` and `match_b_n` are 0 while the count equals compare A or B respectively, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_stb | input | 1 | Count-up strobe, one cycle per step |
| dn_stb | input | 1 | Count-down strobe, one cycle per step |
| load_pin | input | 1 | Asynchronous load request, rising edge active |
| latch_pin | input | 1 | Asynchronous capture request, rising edge active |
| idx_z | input | 1 | Index qualifier, must be 1 for clear |
| idx_a | input | 1 | Index edge source |
| idx_b | input | 1 | Index qualifier, must be 0 for clear |
| clr_on_fall | input | 1 | 0: clear on rising `idx_a`, 1: on falling |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Write target: 0 preload, 1 compare A, 2 compare B |
| wr_data | input | 24 | Write data |
| hold_a | input | 1 | Held mode for comparator A |
| hold_b | input | 1 | Held mode for comparator B |
| ack_a | input | 1 | Release for held output A |
| ack_b | input | 1 | Release for held output B |
| count | output | 24 | Current count |
| latch_val | output | 24 | Captured count |
| coin_a | output | 1 | Coincidence output A |
| coin_b | output | 1 | Coincidence output B |
| match_a_n | output | 1 | Active-low equality flag A |
| match_b_n | output | 1 | Active-low equality flag B |

## Verification
A wrong priority choice or a missed wrap shows on `count` at the very next sampled cycle, and it persists, so every later comparison then disagrees. A synchronizer stage too many or too few moves a load, capture or clear one cycle away from the third edge, and the check exactly there catches it. A comparator machine stuck in HELD or WATCH shows on its coincidence output within one cycle of a match or an acknowledge. Long random up/down runs compare every cycle's count and match flags against a bench model.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
    typedef enum logic [2:0] {
        ACT_KEEP,
        ACT_LOAD,
        ACT_CLEAR,
        ACT_UP,
        ACT_DOWN
    } cnt_act_e;

    typedef enum logic {
        CO_WATCH,
        CO_HELD
    } coin_state_e;

    typedef enum logic [1:0] {
        WSEL_PRE  = 2'd0,
        WSEL_CMPA = 2'd1,
        WSEL_CMPB = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;
endpackage

// File: rtl/qcnt_edge_sync.sv
module qcnt_edge_sync #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s0_q, s1_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q   <= '0;
            s1_q   <= '0;
            prev_q <= '0;
        end else begin
            s0_q   <= pins;
            s1_q   <= s0_q;
            prev_q <= s1_q;
        end
    end

    assign lvl  = s1_q;
    assign rise = s1_q & ~prev_q;
    assign fall = ~s1_q & prev_q;
endmodule

// File: rtl/qcnt_coin_unit.sv
module qcnt_coin_unit
    import qcnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic         hold_mode,
    input  logic         ack,
    output logic         coin,
    output logic         match_n
);
    coin_state_e state_q, state_d;
    logic        eq;

    assign eq = (count == cmp);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CO_WATCH: if (hold_mode && eq && !ack) state_d = CO_HELD;
            CO_HELD:  if (ack || !hold_mode)       state_d = CO_WATCH;
            default:  state_d = CO_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CO_WATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        match_n = !eq;
        coin    = hold_mode ? (state_q == CO_HELD) : eq;
    end

    AST_HELD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && coin && !ack) |=> (!hold_mode || coin)); // R10
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && ack) |=> (!hold_mode || !coin)); // R10
    AST_HELD_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && !coin && !eq) |=> (!hold_mode || !coin)); // R10
endmodule

// File: rtl/qcnt_compare.sv
module qcnt_compare
    import qcnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_stb,
    input  logic         dn_stb,
    input  logic         load_pin,
    input  logic         latch_pin,
    input  logic         idx_z,
    input  logic         idx_a,
    input  logic         idx_b,
    input  logic         clr_on_fall,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         hold_a,
    input  logic         hold_b,
    input  logic         ack_a,
    input  logic         ack_b,
    output logic [W-1:0] count,
    output logic [W-1:0] latch_val,
    output logic         coin_a,
    output logic         coin_b,
    output logic         match_a_n,
    output logic         match_b_n
);
    localparam int NPIN  = 5;
    localparam int P_LD  = 0;
    localparam int P_LT  = 1;
    localparam int P_Z   = 2;
    localparam int P_A   = 3;
    localparam int P_B   = 4;
    localparam int NCMP  = 2;

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic [W-1:0]    cnt_q, cnt_d, pre_q, ltc_q;
    logic [W-1:0]    cmp_q [NCMP];
    logic            load_evt, latch_evt, clr_evt, a_edge;
    cnt_act_e        act;
    logic [NCMP-1:0] hold_v, ack_v, coin_v, match_v;

    qcnt_edge_sync #(.N(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  ({idx_b, idx_a, idx_z, latch_pin, load_pin}),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    assign load_evt  = pin_rise[P_LD];
    assign latch_evt = pin_rise[P_LT];
    assign a_edge    = clr_on_fall ? pin_fall[P_A] : pin_rise[P_A];
    assign clr_evt   = a_edge && pin_lvl[P_Z] && !pin_lvl[P_B];

    always_comb begin
        if (load_evt)                act = ACT_LOAD;
        else if (clr_evt)            act = ACT_CLEAR;
        else if (up_stb && !dn_stb)  act = ACT_UP;
        else if (dn_stb && !up_stb)  act = ACT_DOWN;
        else                         act = ACT_KEEP;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_LOAD:  cnt_d = pre_q;
            ACT_CLEAR: cnt_d = '0;
            ACT_UP:    cnt_d = cnt_q + 1'b1;
            ACT_DOWN:  cnt_d = cnt_q - 1'b1;
            ACT_KEEP:  cnt_d = cnt_q;
            default:   cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ltc_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (latch_evt) ltc_q <= cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            cmp_q[0] <= '0;
            cmp_q[1] <= '0;
        end else if (wr_en) begin
            unique case (wsel_e'(wr_sel))
                WSEL_PRE:  pre_q    <= wr_data;
                WSEL_CMPA: cmp_q[0] <= wr_data;
                WSEL_CMPB: cmp_q[1] <= wr_data;
                WSEL_NONE: ;
                default:   ;
            endcase
        end
    end

    assign hold_v = {hold_b, hold_a};
    assign ack_v  = {ack_b, ack_a};

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        qcnt_coin_unit #(.W(W)) u_coin (
            .clk       (clk),
            .rst_n     (rst_n),
            .count     (cnt_q),
            .cmp       (cmp_q[g]),
            .hold_mode (hold_v[g]),
            .ack       (ack_v[g]),
            .coin      (coin_v[g]),
            .match_n   (match_v[g])
        );
    end

    assign count     = cnt_q;
    assign latch_val = ltc_q;
    assign coin_a    = coin_v[0];
    assign coin_b    = coin_v[1];
    assign match_a_n = match_v[0];
    assign match_b_n = match_v[1];

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (count == $past(pre_q))); // R4
    AST_LATCH_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        latch_evt |=> (latch_val == $past(count))); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !load_evt) |=> (count == '0)); // R7
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && !clr_evt && up_stb && !dn_stb) |=> (count == $past(count) + 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_evt && !clr_evt && (up_stb == dn_stb)) |=> $stable(count)); // R2
endmodule

// File: tb/qcnt_compare_tb_top.sv
module qcnt_compare_tb_top;
    localparam int W = 24;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         up_stb = 0, dn_stb = 0, load_pin = 0, latch_pin = 0;
    logic         idx_z = 0, idx_a = 0, idx_b = 0, clr_on_fall = 0;
    logic         wr_en = 0;
    logic [1:0]   wr_sel = 0;
    logic [W-1:0] wr_data = 0;
    logic         hold_a = 0, hold_b = 0, ack_a = 0, ack_b = 0;
    logic [W-1:0] count, latch_val;
    logic         coin_a, coin_b, match_a_n, match_b_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] model, cmpa_m, cmpb_m;

    always #2 clk = ~clk;

    qcnt_compare #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .up_stb(up_stb), .dn_stb(dn_stb),
        .load_pin(load_pin), .latch_pin(latch_pin), .idx_z(idx_z), .idx_a(idx_a),
        .idx_b(idx_b), .clr_on_fall(clr_on_fall), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .hold_a(hold_a), .hold_b(hold_b), .ack_a(ack_a), .ack_b(ack_b),
        .count(count), .latch_val(latch_val), .coin_a(coin_a), .coin_b(coin_b),
        .match_a_n(match_a_n), .match_b_n(match_b_n)
    );

    function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic u, input logic d);
        if (u && !d)      return v + 1'b1;
        else if (d && !u) return v - 1'b1;
        else              return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic load_to(input logic [W-1:0] v);
        wr(2'd0, v);
        load_pin = 1;
        tick(3);
        load_pin = 0;
        tick(2);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        @(negedge clk);
        tick(2);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 latch", latch_val, 0);
        chk("R1 match_a_n", match_a_n, 0);
        chk("R1 coin_b", coin_b, 1);
        // R8 write targets; sel 3 has no effect
        wr(2'd1, 24'h000010);
        wr(2'd2, 24'h000020);
        wr(2'd3, 24'h000000);
        chk("R8 cmpA via match", match_a_n, 1);
        load_to(24'h000010);
        chk("R8 preload", count, 24'h10);
        chk("R11 match_a_n low", match_a_n, 0);
        chk("R9 coin_a momentary", coin_a, 1);
        chk("R11 match_b_n high", match_b_n, 1);
        // R3 wrap up and down
        load_to(MAXV);
        up_stb = 1; tick(); up_stb = 0;
        chk("R3 wrap up", count, 0);
        dn_stb = 1; tick(); dn_stb = 0;
        chk("R3 wrap down", count, MAXV);
        // R2 both strobes: no change
        up_stb = 1; dn_stb = 1; tick(); up_stb = 0; dn_stb = 0;
        chk("R2 both strobes", count, MAXV);
        // R4 load timing and priority
        wr(2'd0, 24'h00ABCD);
        load_pin = 1;
        tick(2);
        chk("R4 not yet loaded", count, MAXV);
        up_stb = 1;
        tick();
        up_stb = 0;
        chk("R4 load beats strobe", count, 24'h00ABCD);
        load_pin = 0; tick(2);
        // R5 latch captures pre-update value
        latch_pin = 1;
        tick(2);
        up_stb = 1; tick(); up_stb = 0;
        chk("R5 latch value", latch_val, 24'h00ABCD);
        chk("R5 count moved", count, 24'h00ABCE);
        latch_pin = 0; tick(2);
        // R6 index clear, rising edge
        idx_z = 1; idx_b = 0; tick(3);
        idx_a = 1; tick(3);
        chk("R6 rising clear", count, 0);
        idx_a = 0; tick(3);
        chk("R6 falling ignored when rising sel", count, 0);
        load_to(24'h000055);
        idx_b = 1; tick(3);
        idx_a = 1; tick(3);
        chk("R6 blocked by idx_b", count, 24'h55);
        idx_b = 0; tick(3);
        clr_on_fall = 1;
        idx_a = 0; tick(3);
        chk("R6 falling clear", count, 0);
        // R7 load beats clear
        wr(2'd0, 24'h000777);
        idx_a = 1; tick(3);
        clr_on_fall = 0;
        idx_a = 0; tick(3);
        load_pin = 1; idx_a = 1; tick(3);
        chk("R7 load over clear", count, 24'h777);
        load_pin = 0; idx_a = 0; idx_z = 0; tick(3);
        // R10 held output
        load_to(24'h000003);
        wr(2'd1, 24'h000005);
        hold_a = 1;
        up_stb = 1; tick(2); up_stb = 0;
        chk("R10 count at match", count, 5);
        chk("R10 not yet held", coin_a, 0);
        tick();
        chk("R10 held set", coin_a, 1);
        up_stb = 1; tick(3); up_stb = 0;
        chk("R10 held sticks", coin_a, 1);
        chk("R9 match_a_n released", match_a_n, 1);
        ack_a = 1; tick(); ack_a = 0;
        chk("R10 ack release", coin_a, 0);
        tick();
        chk("R10 stays released", coin_a, 0);
        hold_a = 0;
        // random phase: R2 R3 R9 R11
        load_to(MAXV - 24'd20);
        model = MAXV - 24'd20;
        cmpa_m = MAXV - 24'd18;
        cmpb_m = 24'd3;
        wr(2'd1, cmpa_m);
        wr(2'd2, cmpb_m);
        for (int i = 0; i < 3000; i++) begin
            logic u, d;
            u = ($urandom % 3) == 0;
            d = ($urandom % 4) == 0;
            up_stb = u; dn_stb = d;
            tick();
            model = step(model, u, d);
            chk("R2 random count", count, model);
            chk("R9 random coin_a", coin_a, model == cmpa_m);
            chk("R11 random match_b_n", match_b_n, model != cmpb_m);
        end
        up_stb = 0; dn_stb = 0;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule